// File: doc/BRIEF.md
# Parity-Protected Issue Queue with Deferred Error Reporting

This block is the in-order instruction queue that sits between a protected instruction fetch path and the execution stage. Each stored instruction carries a parity bit that the queue computes as the instruction is written. Parity is checked only when the instruction leaves for execution. A mismatch does not raise an error at once. Instead, a per-instruction "suspect" tag travels with the instruction. The block remembers that tag for every issued instruction until the instruction commits. A machine-check is signalled only for tagged instructions that actually retire. Instructions that commit as wrong-path or predicated-false are dropped silently.

Instruction types that cannot change architectural state (no-op, prefetch, prediction hint) are never tagged, whatever their parity says. A load holds back further issue until the memory side answers. If the answer is a first-level miss, every instruction still waiting in the queue is younger than that load, and all of them are discarded. This shortens the time they sit exposed in unprotected storage. The fetch sequence pointer then rewinds to the instruction after the load. Fetch stays paused until the miss is reported resolved, and then the discarded instructions are fetched again.

A test input flips one chosen data bit of a stored entry, addressed by its distance from the oldest entry, so that the parity path can be exercised.

Top module: `defer_err_iq`

## Requirements
- R1: After reset the queue and the commit tracker are empty: `iss_valid` and `mchk_valid` are low, `fetch_seq` is 0 and `fetch_req` is high.
- R2: Instructions are accepted when `fetch_req` and `fetch_valid` are both high, and only while fewer than DEPTH entries are held. Each accepted instruction takes the current `fetch_seq` as its sequence number, and `fetch_seq` then advances by one, wrapping modulo 2^SEQW. Instructions leave through the issue port in that order, with word, type and sequence number unchanged.
- R3: Parity covers the 3-bit type field and the instruction word. When the stored word or type no longer matches the stored parity at issue, `iss_tag` is high. Issuing a tagged instruction never raises `mchk_valid` by itself.
- R4: Type codes 4 to 7 (type bit 2 set: no-op, prefetch, hint and the reserved code) are error-neutral, and `iss_tag` is always low for them.
- R5: When `cmt_valid` is high, the oldest issued but uncommitted instruction commits. If its tag was set and `cmt_wrong` is low, `mchk_valid` pulses high for exactly the next cycle, with `mchk_seq` equal to that instruction's sequence number.
- R6: A commit with `cmt_wrong` high (wrong path or predicated false) never produces `mchk_valid`, whatever the tag.
- R7: Issuing an instruction of type 1 (load) holds `iss_valid` low until the cycle after `ld_resp_valid` is seen.
- R8: A load response with `ld_resp_miss` high discards every queued entry. From the next cycle `fetch_seq` equals the load's sequence number plus one, and the next instruction issued carries that number.
- R9: After a miss, `fetch_req` stays low through the cycle in which `refill_done` is high, and returns high in the cycle after it. In the cycle of the missing response itself, no instruction is accepted.
- R10: At most TRK_DEPTH instructions can be issued and uncommitted at once. While that many are outstanding, `iss_valid` stays low. Commits retire instructions in issue order.
- R11: When `inj_en` is high, bit `inj_bit` of the word held `inj_off` places behind the oldest entry is inverted, and the parity bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | output | 1 | Queue can accept an instruction this cycle |
| fetch_seq | output | SEQW | Sequence number of the next instruction wanted |
| fetch_valid | input | 1 | Fetch side presents an instruction |
| fetch_word | input | XLEN | Instruction word being fetched |
| fetch_kind | input | 3 | Instruction type code |
| iss_valid | output | 1 | Oldest entry is offered for issue |
| iss_ready | input | 1 | Execution stage takes the offered entry |
| iss_word | output | XLEN | Issued instruction word as stored |
| iss_kind | output | 3 | Issued instruction type code |
| iss_seq | output | SEQW | Issued instruction sequence number |
| iss_tag | output | 1 | Suspect tag from the parity check at issue |
| ld_resp_valid | input | 1 | Memory answer for the outstanding load |
| ld_resp_miss | input | 1 | The answer is a first-level miss |
| refill_done | input | 1 | Miss resolved, refetch may begin |
| cmt_valid | input | 1 | Oldest outstanding instruction commits |
| cmt_wrong | input | 1 | The committing instruction is wrong-path or predicated false |
| mchk_valid | output | 1 | One-cycle machine-check pulse |
| mchk_seq | output | SEQW | Sequence number of the failing instruction |
| inj_en | input | 1 | Test: flip one stored data bit |
| inj_off | input | log2(DEPTH) | Test: entry distance from the oldest entry |
| inj_bit | input | log2(XLEN) | Test: bit index within the word |

## Verification
The bench keeps the default build: DEPTH 8, XLEN 32, SEQW 8, TRK_DEPTH 8. An 8-deep queue and tracker fill within a few cycles of withheld issue or commit, so the back-pressure paths are reached often. An 8-bit sequence number wraps several times within a few thousand cycles, so a rewind across the wrap point occurs under random stimulus. A 256-entry program indexed by sequence number lets the bench model every refetch and every injected flip exactly.

// File: rtl/iq_pkg.sv
// Shared constants and helpers for the deferred-error issue queue.
// Assumes a 3-bit instruction type code with bit 2 marking error-neutral types.
package iq_pkg;
    localparam int KIND_W      = 3;
    localparam int NEUTRAL_BIT = 2;
    localparam logic [KIND_W-1:0] KIND_LOAD = 3'd1;

    // True for types whose corruption cannot affect program outcome.
    function automatic logic kind_is_neutral(input logic [KIND_W-1:0] k);
        return k[NEUTRAL_BIT];
    endfunction

    // True for memory reads that can miss in the first-level cache.
    function automatic logic kind_is_load(input logic [KIND_W-1:0] k);
        return k == KIND_LOAD;
    endfunction
endpackage

// File: rtl/iq_store.sv
// Circular entry storage with write-time parity and issue-time check.
// Assumes DEPTH is a power of two (pointer and offset arithmetic wrap naturally),
// push never coincides with flush, and push is never requested when full.
module iq_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int SEQW  = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int BITW = $clog2(XLEN),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [XLEN-1:0]   push_word,
    input  logic [KIND_W-1:0] push_kind,
    input  logic [SEQW-1:0]   push_seq,
    input  logic              pop,
    input  logic              flush,
    input  logic              inj_en,
    input  logic [PTRW-1:0]   inj_off,
    input  logic [BITW-1:0]   inj_bit,
    output logic              full,
    output logic              head_valid,
    output logic [XLEN-1:0]   head_word,
    output logic [KIND_W-1:0] head_kind,
    output logic [SEQW-1:0]   head_seq,
    output logic              head_tag
);
    logic [PTRW-1:0] head_q, tail_q;
    logic [CNTW-1:0] count_q;
    logic [PTRW-1:0] inj_slot;

    logic [XLEN-1:0]   word_a [DEPTH];
    logic [KIND_W-1:0] kind_a [DEPTH];
    logic [SEQW-1:0]   seq_a  [DEPTH];
    logic              par_a  [DEPTH];
    logic              vld_a  [DEPTH];

    // Physical slot addressed by the test flip, counted from the oldest entry.
    assign inj_slot = head_q + inj_off;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [XLEN-1:0]   word_r;
        logic [KIND_W-1:0] kind_r;
        logic [SEQW-1:0]   seq_r;
        logic              par_r;
        logic              vld_r;
        logic              wr_here, flip_here, clr_here;

        assign wr_here   = push && (tail_q == PTRW'(i));
        assign flip_here = inj_en && (inj_slot == PTRW'(i));
        assign clr_here  = flush || (pop && (head_q == PTRW'(i)));

        // Slot register: load on write, flip on injection, drop on pop or flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_r <= '0;
                kind_r <= '0;
                seq_r  <= '0;
                par_r  <= 1'b0;
                vld_r  <= 1'b0;
            end else if (wr_here) begin
                word_r <= push_word;
                kind_r <= push_kind;
                seq_r  <= push_seq;
                par_r  <= ^{push_kind, push_word};
                vld_r  <= 1'b1;
            end else begin
                if (flip_here) word_r[inj_bit] <= ~word_r[inj_bit];
                if (clr_here)  vld_r <= 1'b0;
            end
        end

        assign word_a[i] = word_r;
        assign kind_a[i] = kind_r;
        assign seq_a[i]  = seq_r;
        assign par_a[i]  = par_r;
        assign vld_a[i]  = vld_r;
    end

    // Pointer and occupancy bookkeeping for the circular buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush) begin
            tail_q  <= head_q;
            count_q <= '0;
        end else begin
            if (pop)  head_q <= head_q + PTRW'(1);
            if (push) tail_q <= tail_q + PTRW'(1);
            count_q <= count_q + CNTW'(push) - CNTW'(pop);
        end
    end

    assign full       = (count_q == CNTW'(DEPTH));
    assign head_valid = vld_a[head_q];
    assign head_word  = word_a[head_q];
    assign head_kind  = kind_a[head_q];
    assign head_seq   = seq_a[head_q];

    // Suspect tag: parity mismatch on a type that can matter.
    always_comb begin
        head_tag = ((^{kind_a[head_q], word_a[head_q]}) ^ par_a[head_q])
                   && !kind_is_neutral(kind_a[head_q]);
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_valid_tracks_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == (count_q != '0));
    assert_pop_only_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);
endmodule

// File: rtl/iq_fetch_ctl.sv
// Fetch sequence pointer, outstanding-load wait and miss refill control.
// Assumes at most one load outstanding, and ld_resp_valid only while one is.
module iq_fetch_ctl
    import iq_pkg::*;
#(
    parameter int SEQW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            store_full,
    input  logic            fetch_valid,
    input  logic            issue_load,
    input  logic [SEQW-1:0] issue_seq,
    input  logic            ld_resp_valid,
    input  logic            ld_resp_miss,
    input  logic            refill_done,
    output logic            fetch_req,
    output logic [SEQW-1:0] fetch_seq,
    output logic            push,
    output logic            squash,
    output logic            ld_wait
);
    logic [SEQW-1:0] seq_q;
    logic [SEQW-1:0] ld_seq_q;
    logic            ld_wait_q;
    logic            refill_q;

    assign squash    = ld_resp_valid && ld_resp_miss && ld_wait_q;
    assign fetch_req = !store_full && !refill_q && !squash;
    assign push      = fetch_req && fetch_valid;
    assign fetch_seq = seq_q;
    assign ld_wait   = ld_wait_q;

    // Fetch pointer: advance per accepted instruction, rewind past a missing load.
    always_ff @(posedge clk) begin
        if (!rst_n)      seq_q <= '0;
        else if (squash) seq_q <= ld_seq_q + SEQW'(1);
        else if (push)   seq_q <= seq_q + SEQW'(1);
    end

    // Outstanding load: record its sequence number, clear on any response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_wait_q <= 1'b0;
            ld_seq_q  <= '0;
        end else if (issue_load) begin
            ld_wait_q <= 1'b1;
            ld_seq_q  <= issue_seq;
        end else if (ld_resp_valid) begin
            ld_wait_q <= 1'b0;
        end
    end

    // Refill hold: fetch paused from a miss until the miss is resolved.
    always_ff @(posedge clk) begin
        if (!rst_n)           refill_q <= 1'b0;
        else if (squash)      refill_q <= 1'b1;
        else if (refill_done) refill_q <= 1'b0;
    end

    assert_rewind_after_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> fetch_seq == $past(ld_seq_q) + SEQW'(1));
    assert_fetch_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !fetch_req);
    assert_held_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_q && !refill_done) |=> !fetch_req);
    assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_load |-> !ld_wait_q);
endmodule

// File: rtl/iq_retire_track.sv
// In-order record of issued instructions and their suspect tags until commit.
// Turns a tag into a machine-check pulse only for a right-path commit.
// Assumes the commit side never commits more instructions than were issued.
module iq_retire_track #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [SEQW-1:0] push_seq,
    input  logic            push_tag,
    input  logic            cmt_valid,
    input  logic            cmt_wrong,
    output logic            full,
    output logic            mchk_valid,
    output logic [SEQW-1:0] mchk_seq
);
    logic [SEQW-1:0] seq_m [DEPTH];
    logic            tag_m [DEPTH];
    logic [PTRW-1:0] head_q, tail_q;
    logic [CNTW-1:0] count_q;
    logic            pop;
    logic            mchk_q;
    logic [SEQW-1:0] mchk_seq_q;

    assign pop  = cmt_valid && (count_q != '0);
    assign full = (count_q == CNTW'(DEPTH));

    // Record storage: written at issue, no reset needed behind the count.
    always_ff @(posedge clk) begin
        if (push) begin
            seq_m[tail_q] <= push_seq;
            tag_m[tail_q] <= push_tag;
        end
    end

    // Pointer and occupancy bookkeeping for outstanding instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= (tail_q == PTRW'(DEPTH - 1)) ? '0 : tail_q + PTRW'(1);
            if (pop)  head_q <= (head_q == PTRW'(DEPTH - 1)) ? '0 : head_q + PTRW'(1);
            count_q <= count_q + CNTW'(push) - CNTW'(pop);
        end
    end

    // Machine-check pulse: tagged, right-path commit reports the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchk_q     <= 1'b0;
            mchk_seq_q <= '0;
        end else begin
            mchk_q <= pop && tag_m[head_q] && !cmt_wrong;
            if (pop) mchk_seq_q <= seq_m[head_q];
        end
    end

    assign mchk_valid = mchk_q;
    assign mchk_seq   = mchk_seq_q;

    assert_mchk_follows_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_valid |-> $past(cmt_valid));
    assert_no_wrong_path_mchk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_valid |-> !$past(cmt_wrong));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_commit_has_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> count_q != '0);
endmodule

// File: rtl/defer_err_iq.sv
// Top of the parity-protected issue queue with deferred error reporting.
// Ties storage, fetch/miss control and the commit tracker together, and gates
// issue on an outstanding load and on a full tracker.
// Assumes an in-order pipeline: everything still queued is younger than any issued load.
module defer_err_iq
    import iq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int XLEN      = 32,
    parameter int SEQW      = 8,
    parameter int TRK_DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int BITW = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    output logic [SEQW-1:0]   fetch_seq,
    input  logic              fetch_valid,
    input  logic [XLEN-1:0]   fetch_word,
    input  logic [KIND_W-1:0] fetch_kind,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [XLEN-1:0]   iss_word,
    output logic [KIND_W-1:0] iss_kind,
    output logic [SEQW-1:0]   iss_seq,
    output logic              iss_tag,
    input  logic              ld_resp_valid,
    input  logic              ld_resp_miss,
    input  logic              refill_done,
    input  logic              cmt_valid,
    input  logic              cmt_wrong,
    output logic              mchk_valid,
    output logic [SEQW-1:0]   mchk_seq,
    input  logic              inj_en,
    input  logic [PTRW-1:0]   inj_off,
    input  logic [BITW-1:0]   inj_bit
);
    logic store_full, head_valid, head_tag;
    logic push, squash, ld_wait, trk_full;
    logic iss_fire, issue_load;

    // Issue gate: head present, no load in flight, room to track it.
    assign iss_valid  = head_valid && !ld_wait && !trk_full;
    assign iss_fire   = iss_valid && iss_ready;
    assign issue_load = iss_fire && kind_is_load(iss_kind);
    assign iss_tag    = head_tag;

    iq_store #(.DEPTH(DEPTH), .XLEN(XLEN), .SEQW(SEQW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_word  (fetch_word),
        .push_kind  (fetch_kind),
        .push_seq   (fetch_seq),
        .pop        (iss_fire),
        .flush      (squash),
        .inj_en     (inj_en),
        .inj_off    (inj_off),
        .inj_bit    (inj_bit),
        .full       (store_full),
        .head_valid (head_valid),
        .head_word  (iss_word),
        .head_kind  (iss_kind),
        .head_seq   (iss_seq),
        .head_tag   (head_tag)
    );

    iq_fetch_ctl #(.SEQW(SEQW)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .store_full    (store_full),
        .fetch_valid   (fetch_valid),
        .issue_load    (issue_load),
        .issue_seq     (iss_seq),
        .ld_resp_valid (ld_resp_valid),
        .ld_resp_miss  (ld_resp_miss),
        .refill_done   (refill_done),
        .fetch_req     (fetch_req),
        .fetch_seq     (fetch_seq),
        .push          (push),
        .squash        (squash),
        .ld_wait       (ld_wait)
    );

    iq_retire_track #(.DEPTH(TRK_DEPTH), .SEQW(SEQW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (iss_fire),
        .push_seq   (iss_seq),
        .push_tag   (head_tag),
        .cmt_valid  (cmt_valid),
        .cmt_wrong  (cmt_wrong),
        .full       (trk_full),
        .mchk_valid (mchk_valid),
        .mchk_seq   (mchk_seq)
    );

    assert_load_blocks_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_load |=> !iss_valid);
    assert_neutral_never_tagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind[NEUTRAL_BIT]) |-> !iss_tag);
    assert_miss_stops_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !iss_valid);
endmodule

// File: tb/test_defer_err_iq.sv
// Random plus directed bench for defer_err_iq, with a sequence-indexed program model.
module test_defer_err_iq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req;
    logic [7:0]  fetch_seq;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic [2:0]  fetch_kind = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [31:0] iss_word;
    logic [2:0]  iss_kind;
    logic [7:0]  iss_seq;
    logic        iss_tag;
    logic        ld_resp_valid = 1'b0;
    logic        ld_resp_miss = 1'b0;
    logic        refill_done = 1'b0;
    logic        cmt_valid = 1'b0;
    logic        cmt_wrong = 1'b0;
    logic        mchk_valid;
    logic [7:0]  mchk_seq;
    logic        inj_en = 1'b0;
    logic [2:0]  inj_off = '0;
    logic [4:0]  inj_bit = '0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    defer_err_iq i_defer_err_iq (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_seq(fetch_seq), .fetch_valid(fetch_valid),
        .fetch_word(fetch_word), .fetch_kind(fetch_kind),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_word(iss_word),
        .iss_kind(iss_kind), .iss_seq(iss_seq), .iss_tag(iss_tag),
        .ld_resp_valid(ld_resp_valid), .ld_resp_miss(ld_resp_miss),
        .refill_done(refill_done), .cmt_valid(cmt_valid), .cmt_wrong(cmt_wrong),
        .mchk_valid(mchk_valid), .mchk_seq(mchk_seq),
        .inj_en(inj_en), .inj_off(inj_off), .inj_bit(inj_bit)
    );

    // Program image and per-sequence flip masks of the currently queued copy.
    logic [31:0] prog_word [256];
    logic [2:0]  prog_kind [256];
    logic [31:0] flip      [256];

    // Model state.
    logic [7:0] m_fetch = '0, m_iss = '0, m_ld_seq = '0;
    bit         m_ldwait = 0, m_refill = 0;
    int         ld_delay = 0, rf_delay = 0;
    logic [7:0] trk_seq [8];
    bit         trk_tag [8];
    int         trk_h = 0, trk_n = 0;
    bit         exp_mchk = 0;
    logic [7:0] exp_mchk_seq = '0;
    int         cmt_pct = 70;
    int         n_tagged = 0, n_mchk = 0, n_miss = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_tag_of(input logic [7:0] s);
        return (^flip[s]) && !prog_kind[s][2];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin
            prog_word[i] = $urandom;
            prog_kind[i] = 3'($urandom_range(0, 7));
            flip[i]      = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(iss_valid == 1'b0, "R1", "iss_valid", iss_valid, 0);
        check(mchk_valid == 1'b0, "R1", "mchk_valid", mchk_valid, 0);
        check(fetch_seq == 8'd0, "R1", "fetch_seq", fetch_seq, 0);
        check(fetch_req == 1'b1, "R1", "fetch_req", fetch_req, 1);

        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            // R5/R6: machine-check pulse for last cycle's commit
            check(mchk_valid == exp_mchk, "R5", "mchk_valid", mchk_valid, exp_mchk);
            if (exp_mchk)
                check(mchk_seq == exp_mchk_seq, "R5", "mchk_seq", mchk_seq, exp_mchk_seq);
            if (mchk_valid) n_mchk++;

            // Directed phases: withhold commits to fill the tracker, then drain.
            if (cyc < 300) cmt_pct = 70;
            else if (cyc < 500) cmt_pct = 0;
            else if (cyc < 700) cmt_pct = 100;
            else cmt_pct = 60;

            begin
                logic [7:0] cnt8;
                cnt8 = m_fetch - m_iss;
                ld_resp_valid = 1'b0; ld_resp_miss = 1'b0; refill_done = 1'b0;
                inj_en = 1'b0;
                if (m_ldwait) begin
                    if (ld_delay == 0) begin
                        ld_resp_valid = 1'b1;
                        ld_resp_miss  = 1'($urandom_range(0, 1));
                    end else ld_delay--;
                end
                if (m_refill) begin
                    if (rf_delay == 0) refill_done = 1'b1;
                    else rf_delay--;
                end
                iss_ready = ($urandom_range(0, 3) != 0);
                if (!ld_resp_valid && cnt8 != 0 && $urandom_range(0, 4) == 0) begin
                    inj_en    = 1'b1;
                    inj_off   = 3'($urandom_range(0, int'(cnt8) - 1));
                    inj_bit   = 5'($urandom_range(0, 31));
                    iss_ready = 1'b0;
                end
                fetch_valid = ($urandom_range(0, 3) != 0);
                fetch_word  = prog_word[m_fetch];
                fetch_kind  = prog_kind[m_fetch];
                cmt_valid   = (trk_n > 0) && ($urandom_range(1, 100) <= cmt_pct);
                cmt_wrong   = ($urandom_range(0, 3) == 0);

                #1;
                begin
                    bit exp_freq, exp_iv, fire_i, fire_f;
                    exp_freq = (cnt8 < 8) && !m_refill && !(ld_resp_valid && ld_resp_miss);
                    exp_iv   = (cnt8 != 0) && !m_ldwait && (trk_n < 8);
                    check(fetch_req == exp_freq, "R9", "fetch_req", fetch_req, exp_freq);
                    check(fetch_seq == m_fetch, "R8", "fetch_seq", fetch_seq, m_fetch);
                    check(iss_valid == exp_iv, "R7/R10 gate", "iss_valid", iss_valid, exp_iv);
                    fire_i = exp_iv && iss_ready;
                    fire_f = exp_freq && fetch_valid;
                    if (fire_i) begin
                        bit et;
                        et = exp_tag_of(m_iss);
                        check(iss_seq == m_iss, "R2", "iss_seq", iss_seq, m_iss);
                        check(iss_word == (prog_word[m_iss] ^ flip[m_iss]), "R11", "iss_word",
                              iss_word, prog_word[m_iss] ^ flip[m_iss]);
                        check(iss_kind == prog_kind[m_iss], "R2", "iss_kind", iss_kind, prog_kind[m_iss]);
                        if (prog_kind[m_iss][2])
                            check(iss_tag == 1'b0, "R4", "iss_tag neutral", iss_tag, 0);
                        else
                            check(iss_tag == et, "R3", "iss_tag", iss_tag, et);
                        if (et) n_tagged++;
                        trk_seq[(trk_h + trk_n) % 8] = m_iss;
                        trk_tag[(trk_h + trk_n) % 8] = et;
                        trk_n++;
                        if (prog_kind[m_iss] == 3'd1) begin
                            m_ldwait = 1; m_ld_seq = m_iss;
                            ld_delay = $urandom_range(0, 3);
                        end
                        m_iss = m_iss + 8'd1;
                    end
                    // R5/R6/R10: commit retires the oldest in issue order
                    if (cmt_valid) begin
                        exp_mchk     = trk_tag[trk_h] && !cmt_wrong;
                        exp_mchk_seq = trk_seq[trk_h];
                        trk_h = (trk_h + 1) % 8;
                        trk_n--;
                    end else exp_mchk = 0;
                    if (inj_en)
                        flip[8'(m_iss + 8'(inj_off))] ^= (32'd1 << inj_bit);
                    if (fire_f) begin
                        flip[m_fetch] = '0;
                        m_fetch = m_fetch + 8'd1;
                    end
                    if (ld_resp_valid) begin
                        m_ldwait = 0;
                        if (ld_resp_miss) begin
                            n_miss++;
                            m_refill = 1;
                            rf_delay = $urandom_range(0, 4);
                            m_fetch  = m_ld_seq + 8'd1;
                        end
                    end
                    if (refill_done) m_refill = 0;
                end
            end
        end

        // Coverage sanity: the random run must reach the deferred-error paths.
        check(n_tagged > 0, "R3", "tagged issues seen", n_tagged, 1);
        check(n_mchk > 0, "R5", "machine checks seen", n_mchk, 1);
        check(n_miss > 0, "R8", "load misses seen", n_miss, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule